// File: doc/BRIEF.md
# Clock-Domain Register Synchronization Bridge

This block sits between a bus that runs on one clock and a peripheral register set that runs on an unrelated second clock, such as the one that drives a timer or calendar counter. Each register address has a synchronization class. A write to a write-synchronized register is handed across the boundary with a toggle request and acknowledge pair. A read of a read-synchronized register returns a value captured in the peripheral clock domain. Registers in the unsynchronized class sit on the bus side and answer at once.

While a transfer is in flight a busy bit is raised. When the transfer completes a sticky sync-done flag is set, and that flag can drive an interrupt. A second synchronized access that arrives during an earlier transfer is not dropped. The bus ready line is held low until the earlier transfer is done, and then the second access goes ahead. A software-reset request clears the peripheral register set once it has crossed the boundary.

The bus is a simple request/ready interface. The master holds `bus_req`, `bus_we`, `bus_addr` and `bus_wdata` stable until it sees `bus_ready` high in a cycle. That cycle completes the access, and for a read `bus_rdata` is valid in that cycle.

Top module: `regsync_bridge`

## Requirements
- R1: Address classes: 0 (control) is synchronized on write only; 4 (counter) and 5 (clock value) are synchronized on write and on read; 6 to 11 (period, compare 0, compare 1, alarm, frequency correction, alarm mask) are synchronized on write only; 1 (status), 2 (flags), 3 (interrupt enable) and 12 to 15 are unsynchronized.
- R2: `sync_busy` is high in the very cycle a synchronized access is accepted or launched, and it stays high until the transfer across the boundary has completed.
- R3: On completion of each synchronized transfer, bit 0 of register 2 (the sync-done flag) becomes 1. Writing 1 to that bit clears it, writing 0 leaves it unchanged, and a completion in the same cycle as a clearing write leaves the flag set.
- R4: A synchronized access presented while a transfer is in flight sees `bus_ready` low until that transfer ends. It then completes, and its effect is later visible on read-back.
- R5: Control register bit 1 is the enable. A write crosses to the peripheral domain and drives `per_enable`. A read of register 0 returns the enable in bit 1 and 0 elsewhere.
- R6: Writes to addresses 4 to 11 are applied in the peripheral domain. A read of addresses 6 to 11 completes at once and returns the last value written.
- R7: A read of address 4 or 5 holds `bus_ready` low until a peripheral-domain capture has returned. It then delivers the peripheral value, which includes every earlier accepted write.
- R8: Accesses to unsynchronized addresses complete in the cycle they are presented, with no stall and no busy. Addresses 12 to 15 read as 0, and writes to them have no effect.
- R9: A control write with bit 0 set is a software reset. It clears all peripheral registers and the enable after crossing, and `sync_busy` stays high until the clear has been done. After it, addresses 4 to 11 read 0 and register 0 reads 0.
- R10: `sync_irq` equals the sync-done flag AND bit 0 of register 3 (interrupt enable). Register 3 reads back its bit 0.
- R11: Bit 0 of register 1 reads the current `sync_busy`, and the other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Bus clock |
| brst_n | input | 1 | Bus-domain synchronous reset, active low |
| pclk | input | 1 | Peripheral clock |
| prst_n | input | 1 | Peripheral-domain synchronous reset, active low |
| bus_req | input | 1 | Access request, held until ready |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Register address |
| bus_wdata | input | DW | Write data |
| bus_ready | output | 1 | Access completes in this cycle |
| bus_rdata | output | DW | Read data, valid with ready |
| sync_busy | output | 1 | Synchronized transfer in flight |
| sync_irq | output | 1 | Sync-done interrupt |
| per_enable | output | 1 | Enable bit in the peripheral domain |

## Verification
The bench builds the bridge with 32-bit data, a 4-bit address and three synchronizer stages. The bus clock is 200 MHz and the peripheral clock has an unrelated 13 ns period. The deeper synchronizer stretches each transfer over many bus cycles, so random back-to-back synchronized accesses reliably land while busy is high and exercise the stall path. The full data width lets random 32-bit patterns expose lost or reordered writes in the counter snapshot and the shadow read-back. Directed cases cover the flag clear rules, the interrupt gating, enable crossing and a software reset issued behind a pending counter write.

// File: rtl/regsync_pkg.sv
// Package: shared register addresses, sync classes and operation kinds
// for the clock-domain register bridge. Assumes an address width of at
// least 4 bits.
package regsync_pkg;

    typedef enum logic [1:0] {
        SC_NONE = 2'd0,
        SC_WR   = 2'd1,
        SC_RD   = 2'd2,
        SC_BOTH = 2'd3
    } sync_class_e;

    typedef enum logic [1:0] {
        OP_WRITE = 2'd0,
        OP_READ  = 2'd1,
        OP_SRST  = 2'd2
    } op_kind_e;

    localparam int unsigned ADDR_CTRL   = 0;
    localparam int unsigned ADDR_STATUS = 1;
    localparam int unsigned ADDR_FLAGS  = 2;
    localparam int unsigned ADDR_IRQEN  = 3;
    localparam int unsigned FIRST_SREG  = 4;   // first peripheral register
    localparam int unsigned NUM_RSYNC   = 2;   // counter and clock value
    localparam int unsigned NUM_SREG    = 8;   // peripheral registers 4..11

    // Map an address to its synchronization class.
    function automatic sync_class_e class_of(input int unsigned a);
        if (a == ADDR_CTRL)
            return SC_WR;
        if (a >= FIRST_SREG && a < FIRST_SREG + NUM_RSYNC)
            return SC_BOTH;
        if (a >= FIRST_SREG + NUM_RSYNC && a < FIRST_SREG + NUM_SREG)
            return SC_WR;
        return SC_NONE;
    endfunction

endpackage

// File: rtl/regsync_tsync.sv
// Module: multi-stage level synchronizer for a toggle signal.
// Assumes the input changes at most once per handshake and is held
// stable long enough to be caught (guaranteed by the toggle protocol).
module regsync_tsync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_one
            // Single flop: shift the asynchronous level in.
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '0;
                else        chain <= d;
            end
        end else begin : g_many
            // Flop chain: shift the asynchronous level through all stages.
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/regsync_bus_side.sv
// Module: bus-clock half of the bridge. It decodes the sync class of
// each access, launches one transfer at a time through a request
// toggle, stalls further synchronized accesses while busy, and keeps
// the unsynchronized registers (flag, interrupt enable) plus shadow
// copies of write-only-synchronized registers.
// Assumes the master holds its request stable until ready, and that
// op_* stay untouched while a transfer is in flight (the peripheral
// side reads them then).
module regsync_bus_side
    import regsync_pkg::*;
#(
    parameter int DW     = 32,
    parameter int AW     = 4,
    parameter int STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic          ready,
    output logic [DW-1:0] rdata,
    output logic          busy,
    output logic          busy_reg,
    output logic          flag_reg,
    output logic          ien_reg,
    output logic          irq,
    output logic          req_tog,
    output op_kind_e      op_kind,
    output logic [AW-1:0] op_addr,
    output logic [DW-1:0] op_data,
    input  logic          ack_tog,
    input  logic [DW-1:0] snap
);
    localparam int IW = $clog2(NUM_SREG);

    sync_class_e   cls;
    logic          wr_sync, rd_sync, launch, ack_s, ack_prev, ack_edge;
    logic          rvalid_q, en_sh;
    logic [DW-1:0] rd_q;
    logic [DW-1:0] shadow [NUM_SREG];
    logic [AW-1:0] rel;
    logic          in_sreg;
    logic [IW-1:0] sidx;

    // Decode the class of the access presented this cycle.
    always_comb begin
        cls     = class_of(int'(addr));
        wr_sync = we && (cls == SC_WR || cls == SC_BOTH);
        rd_sync = !we && (cls == SC_RD || cls == SC_BOTH);
        rel     = addr - AW'(FIRST_SREG);
        in_sreg = (addr >= AW'(FIRST_SREG)) && (rel < AW'(NUM_SREG));
        sidx    = rel[IW-1:0];
    end

    regsync_tsync #(.STAGES(STAGES)) u_ack_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (ack_tog),
        .q    (ack_s)
    );

    assign ack_edge = ack_s ^ ack_prev;

    // Launch a new transfer only when idle; a waiting read is not relaunched.
    assign launch = req && !busy_reg && (wr_sync || (rd_sync && !rvalid_q));

    // Ready: unsynchronized at once, sync writes when idle, sync reads on snapshot.
    always_comb begin
        if (!req)         ready = 1'b0;
        else if (wr_sync) ready = !busy_reg;
        else if (rd_sync) ready = rvalid_q;
        else              ready = 1'b1;
    end

    assign busy = busy_reg | launch;
    assign irq  = flag_reg & ien_reg;

    // Transfer state: busy, request toggle, held operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_reg <= 1'b0;
            req_tog  <= 1'b0;
            ack_prev <= 1'b0;
            op_kind  <= OP_WRITE;
            op_addr  <= '0;
            op_data  <= '0;
        end else begin
            ack_prev <= ack_s;
            if (launch) begin
                busy_reg <= 1'b1;
                req_tog  <= ~req_tog;
                op_addr  <= addr;
                op_data  <= wdata;
                if (!we)
                    op_kind <= OP_READ;
                else if (addr == AW'(ADDR_CTRL) && wdata[0])
                    op_kind <= OP_SRST;
                else
                    op_kind <= OP_WRITE;
            end else if (ack_edge) begin
                busy_reg <= 1'b0;
            end
        end
    end

    // Snapshot capture and hand-off to the waiting read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rvalid_q <= 1'b0;
            rd_q     <= '0;
        end else if (ack_edge && op_kind == OP_READ) begin
            rvalid_q <= 1'b1;
            rd_q     <= snap;
        end else if (req && rd_sync && rvalid_q) begin
            rvalid_q <= 1'b0;
        end
    end

    // Sticky sync-done flag: completion sets, write-one clears, set wins.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_reg <= 1'b0;
        else if (ack_edge)
            flag_reg <= 1'b1;
        else if (req && we && addr == AW'(ADDR_FLAGS) && wdata[0])
            flag_reg <= 1'b0;
    end

    // Interrupt enable register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ien_reg <= 1'b0;
        else if (req && we && addr == AW'(ADDR_IRQEN))
            ien_reg <= wdata[0];
    end

    // Shadow copies: updated on accepted writes, cleared when a reset completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_sh <= 1'b0;
            for (int i = 0; i < NUM_SREG; i++) shadow[i] <= '0;
        end else if (ack_edge && op_kind == OP_SRST) begin
            en_sh <= 1'b0;
            for (int i = 0; i < NUM_SREG; i++) shadow[i] <= '0;
        end else if (launch && we) begin
            if (addr == AW'(ADDR_CTRL) && !wdata[0])
                en_sh <= wdata[1];
            if (in_sreg)
                shadow[sidx] <= wdata;
        end
    end

    // Read data mux.
    always_comb begin
        rdata = '0;
        if (rd_sync)
            rdata = rd_q;
        else if (addr == AW'(ADDR_CTRL))
            rdata[1] = en_sh;
        else if (addr == AW'(ADDR_STATUS))
            rdata[0] = busy;
        else if (addr == AW'(ADDR_FLAGS))
            rdata[0] = flag_reg;
        else if (addr == AW'(ADDR_IRQEN))
            rdata[0] = ien_reg;
        else if (in_sreg)
            rdata = shadow[sidx];
    end
endmodule

// File: rtl/regsync_periph_side.sv
// Module: peripheral-clock half of the bridge. It detects each request
// toggle, applies the held operation to the peripheral register file
// (write, snapshot capture or software reset) and returns an
// acknowledge toggle. Assumes op_* are stable from the request toggle
// until the acknowledge has been seen by the bus side.
module regsync_periph_side
    import regsync_pkg::*;
#(
    parameter int DW     = 32,
    parameter int AW     = 4,
    parameter int STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_tog,
    input  op_kind_e      op_kind,
    input  logic [AW-1:0] op_addr,
    input  logic [DW-1:0] op_data,
    output logic          ack_tog,
    output logic [DW-1:0] snap,
    output logic          enable
);
    localparam int IW = $clog2(NUM_SREG);

    logic          req_s, req_prev, go;
    logic [DW-1:0] preg [NUM_SREG];
    logic [AW-1:0] rel;
    logic          in_sreg;
    logic [IW-1:0] pidx;

    regsync_tsync #(.STAGES(STAGES)) u_req_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (req_tog),
        .q    (req_s)
    );

    assign go = req_s ^ req_prev;

    // Decode the register index of the held operation.
    always_comb begin
        rel     = op_addr - AW'(FIRST_SREG);
        in_sreg = (op_addr >= AW'(FIRST_SREG)) && (rel < AW'(NUM_SREG));
        pidx    = rel[IW-1:0];
    end

    // Handshake, enable bit and snapshot capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_prev <= 1'b0;
            ack_tog  <= 1'b0;
            snap     <= '0;
            enable   <= 1'b0;
        end else begin
            req_prev <= req_s;
            if (go) begin
                ack_tog <= ~ack_tog;
                case (op_kind)
                    OP_SRST:  enable <= 1'b0;
                    OP_READ:  snap   <= in_sreg ? preg[pidx] : '0;
                    default:  if (op_addr == AW'(ADDR_CTRL)) enable <= op_data[1];
                endcase
            end
        end
    end

    // Peripheral register file: written or cleared by crossed operations.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_SREG; i++) preg[i] <= '0;
        end else if (go && op_kind == OP_SRST) begin
            for (int i = 0; i < NUM_SREG; i++) preg[i] <= '0;
        end else if (go && op_kind == OP_WRITE && in_sreg) begin
            preg[pidx] <= op_data;
        end
    end
endmodule

// File: rtl/regsync_bridge.sv
// Module: top of the clock-domain register bridge. Joins the bus-side
// and peripheral-side halves through the toggle handshake. Assumes each
// reset input is already synchronous to its own clock.
module regsync_bridge
    import regsync_pkg::*;
#(
    parameter int DW     = 32,
    parameter int AW     = 4,
    parameter int STAGES = 2
) (
    input  logic          bclk,
    input  logic          brst_n,
    input  logic          pclk,
    input  logic          prst_n,
    input  logic          bus_req,
    input  logic          bus_we,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic          bus_ready,
    output logic [DW-1:0] bus_rdata,
    output logic          sync_busy,
    output logic          sync_irq,
    output logic          per_enable
);
    logic          req_tog, ack_tog;
    logic          busy_reg, flag_reg, ien_reg;
    op_kind_e      op_kind;
    logic [AW-1:0] op_addr;
    logic [DW-1:0] op_data, snap;

    regsync_bus_side #(.DW(DW), .AW(AW), .STAGES(STAGES)) u_bus (
        .clk     (bclk),
        .rst_n   (brst_n),
        .req     (bus_req),
        .we      (bus_we),
        .addr    (bus_addr),
        .wdata   (bus_wdata),
        .ready   (bus_ready),
        .rdata   (bus_rdata),
        .busy    (sync_busy),
        .busy_reg(busy_reg),
        .flag_reg(flag_reg),
        .ien_reg (ien_reg),
        .irq     (sync_irq),
        .req_tog (req_tog),
        .op_kind (op_kind),
        .op_addr (op_addr),
        .op_data (op_data),
        .ack_tog (ack_tog),
        .snap    (snap)
    );

    regsync_periph_side #(.DW(DW), .AW(AW), .STAGES(STAGES)) u_per (
        .clk    (pclk),
        .rst_n  (prst_n),
        .req_tog(req_tog),
        .op_kind(op_kind),
        .op_addr(op_addr),
        .op_data(op_data),
        .ack_tog(ack_tog),
        .snap   (snap),
        .enable (per_enable)
    );
endmodule

// File: rtl/regsync_checker.sv
// Checker: temporal properties of the bus-side behaviour of the bridge,
// bound into every instance of the top module.
module regsync_checker
    import regsync_pkg::*;
#(
    parameter int DW = 32,
    parameter int AW = 4
) (
    input logic          bclk,
    input logic          brst_n,
    input logic          bus_req,
    input logic          bus_we,
    input logic [AW-1:0] bus_addr,
    input logic          bus_ready,
    input logic [DW-1:0] bus_rdata,
    input logic          sync_busy,
    input logic          sync_irq,
    input logic          busy_reg,
    input logic          flag_reg,
    input logic          ien_reg
);
    sync_class_e c;
    logic        wr_acc, rd_acc;

    always_comb begin
        c      = class_of(int'(bus_addr));
        wr_acc = bus_req && bus_we && (c == SC_WR || c == SC_BOTH);
        rd_acc = bus_req && !bus_we && (c == SC_RD || c == SC_BOTH);
    end

    // R2: an accepted synchronized write shows busy in its own cycle.
    p_busy_on_accept_r2: assert property (@(posedge bclk) disable iff (!brst_n)
        (wr_acc && bus_ready) |-> sync_busy);

    // R2: once launched, the transfer stays busy in the following cycle.
    p_busy_after_accept_r2: assert property (@(posedge bclk) disable iff (!brst_n)
        (wr_acc && bus_ready) |=> busy_reg);

    // R4: a synchronized access during a transfer is stalled.
    p_stall_when_busy_r4: assert property (@(posedge bclk) disable iff (!brst_n)
        ((wr_acc || rd_acc) && busy_reg) |-> !bus_ready);

    // R3: the end of every transfer leaves the flag set.
    p_flag_on_done_r3: assert property (@(posedge bclk) disable iff (!brst_n)
        $fell(busy_reg) |-> flag_reg);

    // R8: unsynchronized accesses never wait.
    p_unsync_at_once_r8: assert property (@(posedge bclk) disable iff (!brst_n)
        (bus_req && !wr_acc && !rd_acc) |-> bus_ready);

    // R7: a snapshot read completes only after its transfer has ended.
    p_snapshot_after_done_r7: assert property (@(posedge bclk) disable iff (!brst_n)
        (rd_acc && bus_ready) |-> !busy_reg);

    // R10: interrupt output gating.
    p_irq_gate_r10: assert property (@(posedge bclk) disable iff (!brst_n)
        sync_irq == (flag_reg && ien_reg));

    // R11: status read reports busy.
    p_status_busy_r11: assert property (@(posedge bclk) disable iff (!brst_n)
        (bus_req && !bus_we && bus_addr == AW'(ADDR_STATUS)) |-> bus_rdata[0] == sync_busy);
endmodule

bind regsync_bridge regsync_checker #(.DW(DW), .AW(AW)) u_chk (
    .bclk     (bclk),
    .brst_n   (brst_n),
    .bus_req  (bus_req),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .bus_ready(bus_ready),
    .bus_rdata(bus_rdata),
    .sync_busy(sync_busy),
    .sync_irq (sync_irq),
    .busy_reg (busy_reg),
    .flag_reg (flag_reg),
    .ien_reg  (ien_reg)
);

// File: tb/sim_regsync_bridge.sv
`timescale 1ns/1ps
module sim_regsync_bridge;
    localparam int DW = 32;
    localparam int AW = 4;
    localparam int STAGES = 3;
    localparam int MAX_STALL = 24;

    logic          bclk = 1'b0, pclk = 1'b0;
    logic          brst_n = 1'b0, prst_n = 1'b0;
    logic          bus_req = 1'b0, bus_we = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic          bus_ready, sync_busy, sync_irq, per_enable;
    logic [DW-1:0] bus_rdata;

    int            n_chk = 0, n_fail = 0;
    logic [DW-1:0] model [16];
    logic          m_en = 1'b0, m_ien = 1'b0;

    always #2.5 bclk = ~bclk;
    always #6.5 pclk = ~pclk;

    regsync_bridge #(.DW(DW), .AW(AW), .STAGES(STAGES)) u0 (
        .bclk(bclk), .brst_n(brst_n), .pclk(pclk), .prst_n(prst_n),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_ready(bus_ready), .bus_rdata(bus_rdata),
        .sync_busy(sync_busy), .sync_irq(sync_irq), .per_enable(per_enable)
    );

    function automatic int cls(input int a);  // 0 none, 1 write, 3 both
        if (a == 0) return 1;
        if (a == 4 || a == 5) return 3;
        if (a >= 6 && a <= 11) return 1;
        return 0;
    endfunction

    function automatic logic [DW-1:0] expect_read(input int a);
        if (a == 0) return {30'b0, m_en, 1'b0};
        if (a == 3) return {31'b0, m_ien};
        if (a >= 4 && a <= 11) return model[a];
        return '0;
    endfunction

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic xfer(input logic w, input int a, input logic [DW-1:0] d,
                        output logic [DW-1:0] rd, output int stall,
                        output logic busy_pre, output logic busy_acc);
        @(negedge bclk);
        #0.5;
        busy_pre = sync_busy;
        bus_req = 1'b1; bus_we = w; bus_addr = AW'(a); bus_wdata = d;
        #0.5;
        stall = 0;
        while (!bus_ready && stall < 200) begin
            @(negedge bclk);
            #1;
            stall++;
        end
        rd = bus_rdata;
        busy_acc = sync_busy;
        @(posedge bclk);
        #1;
        bus_req = 1'b0;
    endtask

    task automatic wait_idle();
        int t = 0;
        @(negedge bclk);
        while (sync_busy && t < 200) begin
            @(negedge bclk);
            t++;
        end
        chk("R2 busy clears", {31'b0, sync_busy}, '0);
    endtask

    // Apply one access, update the model and check the outcome.
    task automatic access(input logic w, input int a, input logic [DW-1:0] d);
        logic [DW-1:0] rd;
        int st;
        logic bp, ba;
        int c = cls(a);
        xfer(w, a, d, rd, st, bp, ba);
        if (w && c != 0) begin
            chk("R4 stall bounded", {31'b0, st > MAX_STALL}, '0);
            if (bp) chk("R4 stall while busy", {31'b0, st > 0}, 32'd1);
            else    chk("R2 no stall when idle", st, '0);
            chk("R2 busy at acceptance", {31'b0, ba}, 32'd1);
            if (a == 0) begin
                if (d[0]) begin
                    for (int i = 4; i <= 11; i++) model[i] = '0;
                    m_en = 1'b0;
                end else begin
                    m_en = d[1];
                end
            end else begin
                model[a] = d;
            end
        end else if (!w && c == 3) begin
            chk("R7 snapshot stalls", {31'b0, st > 0}, 32'd1);
            chk("R7 stall bounded", {31'b0, st > 2 * MAX_STALL}, '0);
            chk("R7 snapshot value", rd, model[a]);
        end else begin
            chk("R8 unsync at once", st, '0);
            if (w && a == 3) m_ien = d[0];
            if (!w && a == 1) chk("R11 status", rd, {31'b0, ba});
            else if (!w && a != 2) chk("R1 R6 R8 read value", rd, expect_read(a));
        end
    endtask

    task automatic read_chk(input string tag, input int a, input logic [DW-1:0] exp);
        logic [DW-1:0] rd;
        int st;
        logic bp, ba;
        xfer(1'b0, a, '0, rd, st, bp, ba);
        chk(tag, rd, exp);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    initial begin : watchdog
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin : stim
        logic [DW-1:0] rd;
        int st;
        logic bp, ba;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 16; i++) model[i] = '0;
        repeat (6) @(posedge pclk);
        brst_n = 1'b1; prst_n = 1'b1;
        @(negedge bclk);

        // Reset state
        chk("R2 reset busy", {31'b0, sync_busy}, '0);
        chk("R10 reset irq", {31'b0, sync_irq}, '0);
        chk("R5 reset enable", {31'b0, per_enable}, '0);
        read_chk("R3 reset flag", 2, '0);
        read_chk("R11 reset status", 1, '0);

        // R6: single synchronized write, then flag and readback
        access(1'b1, 6, 32'hA5A5_0001);
        chk("R2 busy held", {31'b0, sync_busy}, 32'd1);
        wait_idle();
        read_chk("R3 flag after done", 2, 32'd1);
        read_chk("R6 period readback", 6, 32'hA5A5_0001);

        // R3: write 0 keeps, write 1 clears
        access(1'b1, 2, 32'h0);
        read_chk("R3 write zero keeps flag", 2, 32'd1);
        access(1'b1, 2, 32'h1);
        read_chk("R3 write one clears flag", 2, 32'd0);

        // R4: back-to-back writes, then counter write followed by snapshot read
        access(1'b1, 7, 32'h1111_2222);
        xfer(1'b1, 8, 32'h3333_4444, rd, st, bp, ba);
        model[8] = 32'h3333_4444;
        chk("R4 back-to-back stalls", {31'b0, st > 0}, 32'd1);
        access(1'b1, 4, 32'hDEAD_BEEF);
        access(1'b0, 4, '0);
        access(1'b1, 5, 32'h0BAD_F00D);
        access(1'b0, 5, '0);
        read_chk("R4 first write kept", 7, 32'h1111_2222);
        read_chk("R4 second write kept", 8, 32'h3333_4444);

        // R10: interrupt gating
        access(1'b1, 3, 32'h1);
        chk("R10 irq with flag set", {31'b0, sync_irq}, 32'd1);
        access(1'b1, 3, 32'h0);
        chk("R10 irq masked", {31'b0, sync_irq}, '0);

        // R5: enable crossing
        access(1'b1, 0, 32'h2);
        wait_idle();
        chk("R5 enable crossed", {31'b0, per_enable}, 32'd1);
        read_chk("R5 control readback", 0, 32'h2);

        // R9: software reset behind a pending counter write
        access(1'b1, 4, 32'h0000_0055);
        access(1'b1, 0, 32'h1);
        chk("R9 busy during reset", {31'b0, sync_busy}, 32'd1);
        wait_idle();
        chk("R9 enable cleared", {31'b0, per_enable}, '0);
        access(1'b0, 4, '0);
        read_chk("R9 period cleared", 6, '0);
        read_chk("R9 control cleared", 0, '0);

        // R8: unused address ignores writes
        access(1'b1, 13, 32'hFFFF_FFFF);
        read_chk("R8 unused reads zero", 13, '0);

        // Random mix
        for (int k = 0; k < 400; k++) begin
            int a = int'($urandom % 16);
            logic w = 1'($urandom % 2);
            logic [DW-1:0] d = $urandom;
            if (a == 0 && w) d[0] = (($urandom % 8) == 0);
            access(w, a, d);
            if (a == 0 && w) begin
                wait_idle();
                chk("R5 R9 enable follows", {31'b0, per_enable}, {31'b0, m_en});
            end
        end
        wait_idle();
        for (int a = 4; a <= 11; a++) access(1'b0, a, '0);

        finish_run();
    end
endmodule